// File: doc/BRIEF.md
# RS-485 Half-Duplex Direction Controller

This block decides, for one UART channel on a shared two-wire RS-485 bus, when the local line driver is switched on. When automatic direction control is on, the driver is switched on as soon as the transmit FIFO or the transmit shift register holds data. After both have drained, the block counts a programmable number of whole bit times, from 0 to 15, using a one-pulse-per-bit tick. It then returns the bus to receive. This turnaround delay gives a distant station time to see the last stop bit before the line is released. If new data arrives while the delay is running, the delay is abandoned and the driver stays on.

The block also produces the transmitter status the host sees. The transmitter-empty flag is set only when nothing is left to send. The transmit-ready interrupt request normally follows the FIFO alone. In automatic direction mode it waits until the shift register is also empty. A halt input stops new characters from being loaded into the shift register, so a character already being shifted out still completes. When automatic control is off, the direction pin is an ordinary host-driven control output. A polarity input chooses which pin level means "transmit".

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While `auto_en` is 0, `dir_pin` equals `manual_lvl` in every cycle, and the controller enters the receive state on the next clock.
- R2: While `auto_en` is 1 and `fifo_empty` or `shreg_empty` is 0, `dir_pin` shows the transmit level from the clock edge that follows.
- R3: After both `fifo_empty` and `shreg_empty` become 1, `dir_pin` holds the transmit level until `delay_bits` pulses of `bit_tick` have been counted. It changes to receive on the clock edge of the last counted pulse. Clock cycles without a tick do not count. With `delay_bits` = 0, it changes on the first clock edge that sees both empty.
- R4: `txrdy_irq` equals `fifo_empty` when `auto_en` is 0. It equals `fifo_empty` AND `shreg_empty` when `auto_en` is 1.
- R5: `txe_flag` is 1 exactly when `fifo_empty` and `shreg_empty` are both 1, in either mode.
- R6: `load_next` is 1 only when `shreg_empty` is 1, `fifo_empty` is 0 and `tx_halt` is 0. A character already in the shift register is therefore never cut short by the halt.
- R7: If `fifo_empty` or `shreg_empty` drops to 0 during the turnaround delay, the output stays at the transmit level. The next idle period then starts a full new delay count from zero.
- R8: With `pol_high` = 1 the transmit level is 1 and the receive level is 0. With `pol_high` = 0 both levels are inverted.
- R9: After reset, with `auto_en` = 1, the controller is in the receive state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | 1 = automatic direction control |
| pol_high | input | 1 | 1 = transmit state drives the pin high |
| manual_lvl | input | 1 | Pin level while automatic control is off |
| delay_bits | input | 4 | Turnaround delay in bit times, 0 to 15 |
| bit_tick | input | 1 | One-cycle pulse once per bit time |
| fifo_empty | input | 1 | Transmit FIFO holds no data |
| shreg_empty | input | 1 | Transmit shift register holds no data |
| tx_halt | input | 1 | Block loading of the next character |
| dir_pin | output | 1 | Line driver direction output |
| txe_flag | output | 1 | Transmitter fully empty |
| txrdy_irq | output | 1 | Transmit-ready interrupt request |
| load_next | output | 1 | Permission to move a FIFO byte into the shift register |

## Verification
The bench sweeps the turnaround delay at 0, 1, 5 and 15 bit times, and puts idle clock cycles between the ticks. An off-by-one counter would release the bus one bit early or late. A counter that runs on the clock rather than on the tick would release it after a few cycles. New data is injected midway through a delay. A design that only pauses its count, instead of restarting it, releases the bus too early on the next idle. The interrupt is checked while the FIFO is empty but the shift register is still busy. A design that ignores the mode raises it early there. The bench also toggles the halt input and the polarity input, and leaves the block in manual mode, to catch a load issued mid-character, an inverted pin, and a pin that ignores the host level.

// File: rtl/rs485_pkg.sv
package rs485_pkg;
  typedef enum logic [1:0] {
    DIR_RX   = 2'd0,
    DIR_TX   = 2'd1,
    DIR_TURN = 2'd2
  } dir_state_e;
endpackage

// File: rtl/rs485_turn_timer.sv
module rs485_turn_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign expired = step && (cnt_inc == {1'b0, limit});

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic idle,
  input  logic zero_dly,
  input  logic expired,
  output logic tx_active,
  output logic in_turn
);
  dir_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!auto_en) begin
      st_d = DIR_RX;
    end else begin
      unique case (st_q)
        DIR_RX:   if (!idle) st_d = DIR_TX;
        DIR_TX:   if (idle)  st_d = zero_dly ? DIR_RX : DIR_TURN;
        DIR_TURN: begin
          if (!idle)                    st_d = DIR_TX;
          else if (zero_dly || expired) st_d = DIR_RX;
        end
        default:  st_d = DIR_RX;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DIR_RX;
    else        st_q <= st_d;
  end

  assign tx_active = (st_q != DIR_RX);
  assign in_turn   = (st_q == DIR_TURN);
endmodule

// File: rtl/rs485_tx_status.sv
module rs485_tx_status (
  input  logic auto_en,
  input  logic fifo_empty,
  input  logic shreg_empty,
  input  logic tx_halt,
  output logic idle,
  output logic txe_flag,
  output logic txrdy_irq,
  output logic load_next
);
  assign idle      = fifo_empty & shreg_empty;
  assign txe_flag  = idle;
  assign txrdy_irq = auto_en ? idle : fifo_empty;
  assign load_next = shreg_empty & ~fifo_empty & ~tx_halt;
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             pol_high,
  input  logic             manual_lvl,
  input  logic [DLY_W-1:0] delay_bits,
  input  logic             bit_tick,
  input  logic             fifo_empty,
  input  logic             shreg_empty,
  input  logic             tx_halt,
  output logic             dir_pin,
  output logic             txe_flag,
  output logic             txrdy_irq,
  output logic             load_next
);
  logic idle, tx_active, in_turn, expired, zero_dly;

  assign zero_dly = (delay_bits == '0);

  rs485_tx_status u_status (
    .auto_en     (auto_en),
    .fifo_empty  (fifo_empty),
    .shreg_empty (shreg_empty),
    .tx_halt     (tx_halt),
    .idle        (idle),
    .txe_flag    (txe_flag),
    .txrdy_irq   (txrdy_irq),
    .load_next   (load_next)
  );

  rs485_dir_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_en   (auto_en),
    .idle      (idle),
    .zero_dly  (zero_dly),
    .expired   (expired),
    .tx_active (tx_active),
    .in_turn   (in_turn)
  );

  rs485_turn_timer #(.CNT_W(DLY_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (~in_turn),
    .step    (in_turn & bit_tick),
    .limit   (delay_bits),
    .expired (expired)
  );

  assign dir_pin = auto_en ? (tx_active ? pol_high : ~pol_high) : manual_lvl;
endmodule

// File: rtl/rs485_dir_checker.sv
module rs485_dir_checker #(
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             auto_en,
  input logic             manual_lvl,
  input logic             dir_pin,
  input logic [DLY_W-1:0] delay_bits,
  input logic             fifo_empty,
  input logic             shreg_empty,
  input logic             tx_halt,
  input logic             tx_active,
  input logic             txe_flag,
  input logic             txrdy_irq,
  input logic             load_next
);
  logic busy;
  assign busy = ~(fifo_empty & shreg_empty);

  assert_manual_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |-> (dir_pin == manual_lvl));

  assert_manual_to_rx_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> !tx_active);

  assert_busy_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && busy) |=> tx_active);

  assert_zero_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !busy && delay_bits == '0) |=> !tx_active);

  assert_irq_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !shreg_empty) |-> !txrdy_irq);

  assert_txe_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !txe_flag);

  assert_halt_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_halt || !shreg_empty) |-> !load_next);
endmodule

bind rs485_dir_ctrl rs485_dir_checker #(.DLY_W(DLY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .auto_en     (auto_en),
  .manual_lvl  (manual_lvl),
  .dir_pin     (dir_pin),
  .delay_bits  (delay_bits),
  .fifo_empty  (fifo_empty),
  .shreg_empty (shreg_empty),
  .tx_halt     (tx_halt),
  .tx_active   (tx_active),
  .txe_flag    (txe_flag),
  .txrdy_irq   (txrdy_irq),
  .load_next   (load_next)
);

// File: tb/sim_rs485_dir_ctrl.sv
`timescale 1ns/1ps
module sim_rs485_dir_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       auto_en, pol_high, manual_lvl, bit_tick;
  logic       fifo_empty, shreg_empty, tx_halt;
  logic [3:0] delay_bits;
  logic       dir_pin, txe_flag, txrdy_irq, load_next;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  rs485_dir_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .pol_high(pol_high),
    .manual_lvl(manual_lvl), .delay_bits(delay_bits), .bit_tick(bit_tick),
    .fifo_empty(fifo_empty), .shreg_empty(shreg_empty), .tx_halt(tx_halt),
    .dir_pin(dir_pin), .txe_flag(txe_flag), .txrdy_irq(txrdy_irq),
    .load_next(load_next)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    bit_tick = 1'b1; step(1); bit_tick = 1'b0;
  endtask

  task automatic go_idle_rx();
    fifo_empty = 1'b1; shreg_empty = 1'b1; delay_bits = 4'd0; step(2);
  endtask

  task automatic t_reset();
    chk("R9 reset receive level", dir_pin, 1'b0);
    chk("R5 reset txe", txe_flag, 1'b1);
  endtask

  task automatic t_manual();
    auto_en = 1'b0; fifo_empty = 1'b0; shreg_empty = 1'b0;
    manual_lvl = 1'b1; step(1);
    chk("R1 manual high", dir_pin, 1'b1);
    manual_lvl = 1'b0; step(2);
    chk("R1 manual low with data", dir_pin, 1'b0);
    chk("R4 manual mode irq follows fifo", txrdy_irq, 1'b0);
    fifo_empty = 1'b1; step(1);
    chk("R4 manual irq with shreg busy", txrdy_irq, 1'b1);
    // enable with nothing pending: must come up in receive state
    shreg_empty = 1'b1; step(1);
    auto_en = 1'b1; step(1);
    chk("R1 enters receive", dir_pin, 1'b0);
  endtask

  task automatic t_busy();
    shreg_empty = 1'b0; fifo_empty = 1'b1; delay_bits = 4'd3; step(1);
    chk("R2 shreg busy drives", dir_pin, 1'b1);
    chk("R4 irq held while shreg busy", txrdy_irq, 1'b0);
    chk("R5 txe low while shreg busy", txe_flag, 1'b0);
    fifo_empty = 1'b0; shreg_empty = 1'b1; step(1);
    chk("R2 fifo busy drives", dir_pin, 1'b1);
    chk("R5 txe low while fifo busy", txe_flag, 1'b0);
    go_idle_rx();
    chk("R4 irq when all empty", txrdy_irq, 1'b1);
  endtask

  task automatic t_delay(input int n);
    delay_bits = 4'(n);
    fifo_empty = 1'b0; shreg_empty = 1'b0; step(1);
    chk("R2 drive before delay", dir_pin, 1'b1);
    fifo_empty = 1'b1; shreg_empty = 1'b1; step(1);
    chk("R3 first idle edge", dir_pin, (n == 0) ? 1'b0 : 1'b1);
    step(3);
    chk("R3 no count without tick", dir_pin, (n == 0) ? 1'b0 : 1'b1);
    for (int i = 0; i < n; i++) begin
      tick();
      if (i < n - 1) begin
        if (i == n - 2 || i == 0) chk("R3 still driving mid delay", dir_pin, 1'b1);
      end else begin
        chk("R3 released after last tick", dir_pin, 1'b0);
      end
      step(1);
    end
    go_idle_rx();
  endtask

  task automatic t_cancel();
    delay_bits = 4'd4;
    fifo_empty = 1'b0; step(1);
    fifo_empty = 1'b1; step(1);
    tick(); tick();
    fifo_empty = 1'b0; step(1);
    chk("R7 new data keeps drive", dir_pin, 1'b1);
    fifo_empty = 1'b1; step(1);
    tick(); tick(); tick();
    chk("R7 full delay restarted", dir_pin, 1'b1);
    tick();
    chk("R7 release after full delay", dir_pin, 1'b0);
    go_idle_rx();
  endtask

  task automatic t_halt();
    tx_halt = 1'b0; fifo_empty = 1'b0; shreg_empty = 1'b0; step(1);
    chk("R6 no load mid character", load_next, 1'b0);
    shreg_empty = 1'b1; step(1);
    chk("R6 load at boundary", load_next, 1'b1);
    tx_halt = 1'b1; step(1);
    chk("R6 halt blocks load", load_next, 1'b0);
    chk("R2 halted data keeps drive", dir_pin, 1'b1);
    tx_halt = 1'b0; fifo_empty = 1'b1; step(1);
    chk("R6 no load when fifo empty", load_next, 1'b0);
    go_idle_rx();
  endtask

  task automatic t_polarity();
    pol_high = 1'b0; step(1);
    chk("R8 inverted receive level", dir_pin, 1'b1);
    fifo_empty = 1'b0; step(1);
    chk("R8 inverted transmit level", dir_pin, 1'b0);
    go_idle_rx();
    chk("R8 inverted back to receive", dir_pin, 1'b1);
    pol_high = 1'b1; step(1);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; auto_en = 1'b1; pol_high = 1'b1; manual_lvl = 1'b0;
    bit_tick = 1'b0; fifo_empty = 1'b1; shreg_empty = 1'b1; tx_halt = 1'b0;
    delay_bits = 4'd0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_manual();
    t_busy();
    t_delay(0);
    t_delay(1);
    t_delay(5);
    t_delay(15);
    t_cancel();
    t_halt();
    t_polarity();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule